// File: doc/BRIEF.md
# Real-Time Clock Holding-Register Synchronizer

This block is the register layer of a real-time clock. It has a free-running prescaler that divides the time-base clock down to one tick per second. The tick advances a calendar core kept in packed BCD: seconds, minutes, 24-hour hours, day of week, date, month and a two-digit year. Month lengths and leap years apply when the date rolls over. Software never touches the core directly. It sees a bank of seven holding registers and one control register.

Three control bits govern the holding registers. Raising the freeze bit copies a coherent image of the core into the holding bank. If a tick lands in the same cycle, the copy holds the advanced time. The image then stays still until the bit is cleared. Raising the stage bit halts the core and opens the holding bank to writes. Clearing the stage bit commits the staged values into the core and restarts the one-second period from that point. A third bit puts a square wave on the calibration pin.

The register port is a plain single-cycle access port. Every write is taken in the cycle it is presented, and a read returns data combinationally from the address. There is no back-pressure and no handshake on either side.

Top module: `rtc_holding_sync`

## Requirements
- R1: After reset the time reads 00:00:00, day of week 01, date 01, month 01, year 00, and all three control bits read 0.
- R2: The core advances once every CLK_HZ cycles. While neither control bit is set, the holding registers follow the core, so the value read is the current time.
- R3: Seconds and minutes count 00 to 59 in BCD, hours count 00 to 23, and day of week counts 01 to 07 and then wraps to 01. The low BCD digit never exceeds 9.
- R4: The date wraps to 01 after 30 in April, June, September and November, and after 31 in the other months. February ends on 29 when the year value is divisible by four and on 28 otherwise. The month wraps from 12 to 01 and the year from 99 to 00.
- R5: Writing the control register (address 0) with bit 0 = 1 while that bit is 0 copies the core into the holding registers. The copy then stays unchanged while bit 0 remains 1 and bit 1 is 0.
- R6: When the freeze bit is raised in the same cycle as a tick, the copy holds the time after that tick.
- R7: While control bit 1 is 1, the core does not change. Any tick in that period is discarded. Writes to addresses 1 to 7 (second, minute, hour, day of week, date, month, year) update the matching holding register.
- R8: Writing the control register with bit 1 = 0 while bit 1 is 1 loads all seven holding registers into the core. The next tick then follows exactly CLK_HZ cycles later.
- R9: Writes to addresses 1 to 7 while control bit 1 is 0 have no effect.
- R10: While control bit 2 is 1, the calibration output is a square wave. It starts low and toggles every CLK_HZ/(2*CAL_HZ) cycles. When bit 2 is 0 the output is low.
- R11: Reading address 0 returns {5'b0, bit2, bit1, bit0}. Addresses above 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| cal_out | output | 1 | Calibration square wave |

## Verification
The bench loads several times just before a rollover and lets one tick pass. The cases are a plain hour rollover, a year-end, February in a leap year and in a non-leap year, February 29, and a 30-day month. Together they separate the month-length logic, the leap rule and the BCD digit carry. A freeze raised exactly on a tick cycle checks whether the snapshot takes the pending update. A tick that falls inside a staging window checks whether the core truly stops and whether the period restarts at the commit. Time writes made while frozen and while tracking check that a write with the stage bit clear can never reach the holding bank.

// File: rtl/rtc_hsync_pkg.sv
package rtc_hsync_pkg;
  localparam int unsigned FIELDS = 7;

  // second occupies the least significant byte; address = field index + 1
  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [7:0] wday;
    logic [7:0] hour;
    logic [7:0] minute;
    logic [7:0] second;
  } rtc_time_t;

  localparam rtc_time_t TIME_INIT = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                      wday: 8'h01, hour: 8'h00, minute: 8'h00,
                                      second: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    logic leap;
    // divisible by four: odd tens need ones of 2 or 6, even tens need 0, 4 or 8
    if (yr[4]) leap = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    else       leap = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic rtc_time_t advance(input rtc_time_t t);
    rtc_time_t n;
    n = t;
    if (t.second != 8'h59) n.second = bcd_inc(t.second);
    else begin
      n.second = 8'h00;
      if (t.minute != 8'h59) n.minute = bcd_inc(t.minute);
      else begin
        n.minute = 8'h00;
        if (t.hour != 8'h23) n.hour = bcd_inc(t.hour);
        else begin
          n.hour = 8'h00;
          n.wday = (t.wday == 8'h07) ? 8'h01 : bcd_inc(t.wday);
          if (t.date != month_last(t.month, t.year)) n.date = bcd_inc(t.date);
          else begin
            n.date = 8'h01;
            if (t.month != 8'h12) n.month = bcd_inc(t.month);
            else begin
              n.month = 8'h01;
              n.year  = (t.year == 8'h99) ? 8'h00 : bcd_inc(t.year);
            end
          end
        end
      end
    end
    return n;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (restart || tick) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_cal_wave.sv
module rtc_cal_wave #(
  parameter int unsigned HALF = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic wave
);
  localparam int unsigned HW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [HW-1:0] LAST = HW'(HALF - 1);

  logic [HW-1:0] cnt_q;
  logic          phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (!enable) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign wave = phase_q & enable;
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_hsync_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      lock,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t now_q,
  output rtc_time_t next_val
);
  always_comb begin
    if (load)              next_val = load_val;
    else if (tick && !lock) next_val = advance(now_q);
    else                   next_val = now_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now_q <= TIME_INIT;
    else        now_q <= next_val;
  end
endmodule

// File: rtl/rtc_user_regs.sv
module rtc_user_regs
  import rtc_hsync_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  rtc_time_t         core_next,
  output logic [7:0]        rd_data,
  output rtc_time_t         hold_q,
  output logic              ctl_read,
  output logic              ctl_write,
  output logic              ctl_cal,
  output logic              commit
);
  localparam int unsigned HW = 8 * FIELDS;

  logic          ctrl_sel, read_rise, follow;
  logic [HW-1:0] hold_vec, core_vec;

  assign core_vec  = core_next;
  assign hold_q    = rtc_time_t'(hold_vec);
  assign ctrl_sel  = wr_en && (wr_addr == '0);
  assign read_rise = ctrl_sel && wr_data[0] && !ctl_read;
  assign commit    = ctrl_sel && !wr_data[1] && ctl_write;
  assign follow    = read_rise || (!ctl_read && !ctl_write);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_read  <= 1'b0;
      ctl_write <= 1'b0;
      ctl_cal   <= 1'b0;
    end else if (ctrl_sel) begin
      ctl_read  <= wr_data[0];
      ctl_write <= wr_data[1];
      ctl_cal   <= wr_data[2];
    end
  end

  for (genvar g = 0; g < FIELDS; g++) begin : g_field
    logic hit;
    assign hit = wr_en && ctl_write && (wr_addr == ADDR_W'(g + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hold_vec[8*g +: 8] <= TIME_INIT[8*g +: 8];
      else if (hit)    hold_vec[8*g +: 8] <= wr_data;
      else if (follow) hold_vec[8*g +: 8] <= core_vec[8*g +: 8];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == '0) rd_data = {5'd0, ctl_cal, ctl_write, ctl_read};
    for (int i = 0; i < FIELDS; i++)
      if (rd_addr == ADDR_W'(i + 1)) rd_data = hold_vec[8*i +: 8];
  end
endmodule

// File: rtl/rtc_holding_sync.sv
module rtc_holding_sync
  import rtc_hsync_pkg::*;
#(
  parameter int unsigned CLK_HZ = 32768,
  parameter int unsigned CAL_HZ = 512,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              cal_out
);
  localparam int unsigned CAL_HALF = CLK_HZ / (2 * CAL_HZ);

  logic      tick, ctl_read, ctl_write, ctl_cal, commit;
  rtc_time_t core_time, core_next, hold_time;

  rtc_prescaler #(.DIV(CLK_HZ)) u_presc (
    .clk(clk), .rst_n(rst_n), .restart(commit), .tick(tick)
  );

  rtc_time_core u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .lock(ctl_write), .load(commit),
    .load_val(hold_time), .now_q(core_time), .next_val(core_next)
  );

  rtc_user_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .core_next(core_next),
    .rd_data(rd_data), .hold_q(hold_time), .ctl_read(ctl_read),
    .ctl_write(ctl_write), .ctl_cal(ctl_cal), .commit(commit)
  );

  rtc_cal_wave #(.HALF(CAL_HALF)) u_cal (
    .clk(clk), .rst_n(rst_n), .enable(ctl_cal), .wave(cal_out)
  );
endmodule

// File: rtl/rtc_holding_sync_chk.sv
module rtc_holding_sync_chk #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              cal_bit,
  input logic              cal_out,
  input logic              ctl_read,
  input logic              ctl_write,
  input logic              commit,
  input logic [55:0]       core_time,
  input logic [55:0]       hold_time
);
  p_track_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_read && !ctl_write) |=> (hold_time == core_time));

  p_sec_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_time[3:0] <= 4'd9) && (core_time[7:0] <= 8'h59));

  p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_read && !ctl_write) |=> $stable(hold_time));

  p_lock_core_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_write && !commit) |=> $stable(core_time));

  p_commit_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (core_time == $past(hold_time)));

  p_cal_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == '0) && !cal_bit) |=> !cal_out);
endmodule

bind rtc_holding_sync rtc_holding_sync_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .cal_bit(wr_data[2]), .cal_out(cal_out), .ctl_read(ctl_read),
  .ctl_write(ctl_write), .commit(commit), .core_time(core_time),
  .hold_time(hold_time)
);

// File: tb/rtc_holding_sync_tb.sv
`timescale 1ns/1ps
module rtc_holding_sync_tb;
  localparam int DIV  = 256;
  localparam int CALF = 4;
  localparam int HALF = DIV / (2 * CALF);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       cal_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  string tag   = "R1";
  int rd_rot   = 0;

  // reference model state, decimal integers; index 0 = second .. 6 = year
  int mc[7] = '{0, 0, 0, 1, 1, 1, 0};
  int mh[7] = '{0, 0, 0, 1, 1, 1, 0};
  int mpc = 0, mcnt = 0;
  bit mr = 0, mw = 0, mcal = 0, mph = 0;

  rtc_holding_sync #(.CLK_HZ(DIV), .CAL_HZ(CALF), .ADDR_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cal_out(cal_out)
  );

  always #4 clk = ~clk;

  function automatic int days_in(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic int to_bcd(int v);
    return (v / 10) * 16 + (v % 10);
  endfunction

  task automatic model_advance(ref int t[7]);
    t[0]++;
    if (t[0] < 60) return;
    t[0] = 0; t[1]++;
    if (t[1] < 60) return;
    t[1] = 0; t[2]++;
    if (t[2] < 24) return;
    t[2] = 0;
    t[3] = (t[3] == 7) ? 1 : t[3] + 1;
    t[4]++;
    if (t[4] <= days_in(t[5], t[6])) return;
    t[4] = 1; t[5]++;
    if (t[5] <= 12) return;
    t[5] = 1;
    t[6] = (t[6] + 1) % 100;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mc = '{0, 0, 0, 1, 1, 1, 0};
      mh = mc;
      mpc = 0; mcnt = 0; mr = 0; mw = 0; mcal = 0; mph = 0;
    end else begin
      bit tk, csel, rrise, cmt;
      int nc[7];
      tk    = (mpc == DIV - 1);
      csel  = wr_en && (wr_addr == 0);
      rrise = csel && wr_data[0] && !mr;
      cmt   = csel && !wr_data[1] && mw;
      nc    = mc;
      if (cmt) nc = mh;
      else if (tk && !mw) model_advance(nc);
      if (wr_en && wr_addr >= 1 && wr_addr <= 7 && mw)
        mh[wr_addr - 1] = wr_data[7:4] * 10 + wr_data[3:0];
      else if (rrise || (!mr && !mw))
        mh = nc;
      mc  = nc;
      mpc = (cmt || tk) ? 0 : mpc + 1;
      if (!mcal) begin mcnt = 0; mph = 0; end
      else if (mcnt == HALF - 1) begin mcnt = 0; mph = !mph; end
      else mcnt++;
      if (csel) begin mr = wr_data[0]; mw = wr_data[1]; mcal = wr_data[2]; end
    end
  end

  task automatic check_now();
    logic [7:0] exp;
    bit ecal;
    if (rd_addr == 0) exp = {5'd0, mcal, mw, mr};
    else if (rd_addr <= 7) exp = 8'(to_bcd(mh[rd_addr - 1]));
    else exp = 8'h00;          // R11 unused address
    n_checks++;
    if (rd_data !== exp) begin
      n_fail++;
      $display("FAIL %s rd_addr=%0d actual=%h expected=%h", tag, rd_addr, rd_data, exp);
    end
    ecal = mcal && mph;
    n_checks++;
    if (cal_out !== ecal) begin
      n_fail++;
      $display("FAIL R10 cal_out actual=%b expected=%b", cal_out, ecal);
    end
  endtask

  task automatic step(input bit we, input int a, input int d);
    @(negedge clk);
    check_now();
    wr_en = we; wr_addr = 4'(a); wr_data = 8'(d);
    rd_addr = 4'(rd_rot);
    rd_rot = (rd_rot + 1) % 9;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  // presents the write so that it meets the tick edge
  task automatic step_on_tick(input int a, input int d);
    forever begin
      @(negedge clk);
      check_now();
      rd_addr = 4'(rd_rot);
      rd_rot = (rd_rot + 1) % 9;
      if (mpc == DIV - 1) break;
      wr_en = 0;
    end
    wr_en = 1; wr_addr = 4'(a); wr_data = 8'(d);
  endtask

  task automatic load_time(input int s, input int mi, input int h, input int wd,
                           input int dt, input int mo, input int y);
    int v[7];
    v = '{s, mi, h, wd, dt, mo, y};
    step(1, 0, 2);
    for (int i = 0; i < 7; i++) step(1, i + 1, v[i]);
    step(1, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";  idle(9);
    tag = "R2";  idle(2 * DIV + 40);
    tag = "R5";  step(1, 0, 1); idle(2 * DIV);
    tag = "R11"; step(1, 0, 0); idle(12);
    tag = "R6";  step_on_tick(0, 1); idle(30); step(1, 0, 0); idle(10);
    tag = "R7";  step(1, 0, 2);
    step(1, 1, 'h59); step(1, 2, 'h59); step(1, 3, 'h23); step(1, 4, 'h07);
    step(1, 5, 'h31); step(1, 6, 'h12); step(1, 7, 'h99);
    idle(DIV + 20);
    tag = "R8";  step(1, 0, 0); idle(DIV + 20);
    tag = "R3";  load_time('h59, 'h59, 'h09, 'h03, 'h15, 'h06, 'h30); idle(DIV + 20);
    tag = "R4";  load_time('h59, 'h59, 'h23, 'h02, 'h28, 'h02, 'h23); idle(DIV + 20);
    load_time('h59, 'h59, 'h23, 'h02, 'h28, 'h02, 'h24); idle(DIV + 20);
    load_time('h59, 'h59, 'h23, 'h05, 'h29, 'h02, 'h24); idle(DIV + 20);
    load_time('h59, 'h59, 'h23, 'h06, 'h30, 'h04, 'h11); idle(DIV + 20);
    tag = "R9";  step(1, 0, 1); step(1, 1, 'h33); step(1, 5, 'h12); idle(20);
    step(1, 0, 0); step(1, 2, 'h44); idle(20);
    tag = "R10"; step(1, 0, 4); idle(4 * HALF + 10); step(1, 0, 0); idle(40);
    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog %s actual=hung expected=finished", tag);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule